// File: doc/BRIEF.md
# Context-Driven Word Processing Element

This block is one cell of a coarse-grain reconfigurable mesh. Each cycle it applies one 16-bit word operation to two operands. Each operand comes through its own selector, from one of four places: a port of the cell's small local RAM, the shared memory bus input, one of the neighbouring cells' outputs, or a constant zero. The operation always produces a registered result that drives the neighbours. The same result can also be stored into the local RAM in the same cycle.

All of this behaviour comes from a single context word held in a reconfiguration register. The context sets the operation, both operand sources, both RAM read addresses, the RAM write address, the write enable and the neighbour select. A new context can be loaded on every clock, so an external sequencer can change the cell's function cycle by cycle. If no new context is loaded, the cell repeats the last one.

Top module: `pe_cell`

## Requirements
- R1: A synchronous active-high reset clears `result_o` to zero and sets the context to an idle word. The idle word is PASS of the zero constant with no RAM write, so `result_o` stays zero until the first context is loaded.
- R2: When `ctx_load` is high at a clock edge, `ctx_word` is captured and governs the following cycle. When `ctx_load` is low, the held context is applied again. The context bits are:
  - [3:0] operation
  - [5:4] source of operand A
  - [7:6] source of operand B
  - [10:8] RAM read address for A
  - [13:11] RAM read address for B
  - [16:14] RAM write address
  - [17] write enable
  - [19:18] neighbour select
- R3: The source code 0 takes the local RAM read port, 1 takes `bus_i`, 2 takes the selected neighbour and 3 takes the constant zero. The same codes apply to both operands.
- R4: Neighbour select k picks `nbr_i[16k+15:16k]`. Both operands share this one neighbour select.
- R5: Opcode 0 gives A+B, opcode 1 gives A-B and opcode 5 gives A*B. All three results are kept modulo 2^16, so MUL returns the low 16 bits of the product.
- R6: Opcode 2 gives A AND B, opcode 3 gives A OR B and opcode 4 gives A XOR B. Opcode 8 passes A through unchanged.
- R7: Opcode 6 shifts A left and opcode 7 shifts A right arithmetically. The shift amount is the low 4 bits of B; the upper bits of B are ignored.
- R8: Opcodes 9 to 15 produce zero.
- R9: The result of the operation for the active context appears on `result_o` at the clock edge that ends that cycle. It holds there for one full cycle.
- R10: With the write enable set, the result is written into the RAM word at the write address at that same edge. With the write enable clear, the RAM is left unchanged.
- R11: A RAM read of the address being written in the same cycle returns the value the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load | input | 1 | Capture `ctx_word` into the reconfiguration register |
| ctx_word | input | 20 | Context word to load |
| bus_i | input | 16 | Shared memory bus operand |
| nbr_i | input | 64 | Four neighbour outputs, neighbour k in bits 16k+15:16k |
| result_o | output | 16 | Registered result toward the neighbours |

## Verification
The bench builds the cell with its defaults: 16-bit words, an 8-word RAM and four neighbours. With only eight addresses, random contexts often read the same word they write in that cycle, which exercises the old-value read rule. Random contexts also reach every neighbour select and, with 16-bit words, every shift amount from 0 to 15. The undefined opcodes are reached as well. Directed steps add the overflow cases for multiply and add, a negative arithmetic shift, and a held context that accumulates into one RAM word.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MUL  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_PASS = 4'd8
  } pe_op_e;

  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_NBR  = 2'd2,
    SRC_ZERO = 2'd3
  } pe_src_e;

  localparam int OP_W  = 4;
  localparam int SRC_W = 2;
endpackage

// File: rtl/pe_ctx_reg.sv
module pe_ctx_reg
  import pe_pkg::*;
#(
  parameter int AW    = 3,
  parameter int NSW   = 2,
  parameter int CTX_W = 2 * SRC_W + OP_W + 3 * AW + 1 + NSW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CTX_W-1:0] word,
  output logic [OP_W-1:0]  op,
  output pe_src_e          src_a,
  output pe_src_e          src_b,
  output logic [AW-1:0]    raddr_a,
  output logic [AW-1:0]    raddr_b,
  output logic [AW-1:0]    waddr,
  output logic             wen,
  output logic [NSW-1:0]   nsel
);
  localparam int SA_LSB  = OP_W;
  localparam int SB_LSB  = SA_LSB + SRC_W;
  localparam int RA_LSB  = SB_LSB + SRC_W;
  localparam int RB_LSB  = RA_LSB + AW;
  localparam int WA_LSB  = RB_LSB + AW;
  localparam int WEN_BIT = WA_LSB + AW;
  localparam int NS_LSB  = WEN_BIT + 1;
  localparam logic [CTX_W-1:0] IDLE_CTX =
    {{(CTX_W - OP_W - 2 * SRC_W){1'b0}}, SRC_ZERO, SRC_ZERO, OP_PASS};

  logic [CTX_W-1:0] ctx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= IDLE_CTX;
    end else if (load) begin
      ctx_q <= word;
    end
  end

  assign op      = ctx_q[0 +: OP_W];
  assign src_a   = pe_src_e'(ctx_q[SA_LSB +: SRC_W]);
  assign src_b   = pe_src_e'(ctx_q[SB_LSB +: SRC_W]);
  assign raddr_a = ctx_q[RA_LSB +: AW];
  assign raddr_b = ctx_q[RB_LSB +: AW];
  assign waddr   = ctx_q[WA_LSB +: AW];
  assign wen     = ctx_q[WEN_BIT];
  assign nsel    = ctx_q[NS_LSB +: NSW];
endmodule

// File: rtl/pe_local_ram.sv
module pe_local_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Reads are asynchronous, so a read in the writing cycle sees the old word.
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pe_operand_mux.sv
module pe_operand_mux
  import pe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  pe_src_e           sel,
  input  logic [DATA_W-1:0] ram_val,
  input  logic [DATA_W-1:0] bus_val,
  input  logic [DATA_W-1:0] nbr_val,
  output logic [DATA_W-1:0] operand
);
  always_comb begin
    unique case (sel)
      SRC_RAM: operand = ram_val;
      SRC_BUS: operand = bus_val;
      SRC_NBR: operand = nbr_val;
      default: operand = '0;
    endcase
  end
endmodule

// File: rtl/pe_fu.sv
module pe_fu
  import pe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    case (pe_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_MUL:  y = a * b;
      OP_SHL:  y = a << shamt;
      OP_SHR:  y = $signed(a) >>> shamt;
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RAM_DEPTH = 8,
  parameter int NBR_COUNT = 4,
  localparam int AW    = $clog2(RAM_DEPTH),
  localparam int NSW   = $clog2(NBR_COUNT),
  localparam int CTX_W = OP_W + 2 * SRC_W + 3 * AW + 1 + NSW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ctx_load,
  input  logic [CTX_W-1:0]            ctx_word,
  input  logic [DATA_W-1:0]           bus_i,
  input  logic [NBR_COUNT*DATA_W-1:0] nbr_i,
  output logic [DATA_W-1:0]           result_o
);
  logic [OP_W-1:0]   cur_op;
  pe_src_e           cur_src_a, cur_src_b;
  logic [AW-1:0]     cur_raddr_a, cur_raddr_b, cur_waddr;
  logic              cur_wen;
  logic [NSW-1:0]    cur_nsel;
  logic [DATA_W-1:0] ram_a, ram_b, opnd_a, opnd_b, fu_y, nbr_pick;
  logic [DATA_W-1:0] nbr_arr [NBR_COUNT];
  logic [DATA_W-1:0] res_q;

  pe_ctx_reg #(.AW(AW), .NSW(NSW), .CTX_W(CTX_W)) u_ctx (
    .clk(clk), .rst(rst), .load(ctx_load), .word(ctx_word),
    .op(cur_op), .src_a(cur_src_a), .src_b(cur_src_b),
    .raddr_a(cur_raddr_a), .raddr_b(cur_raddr_b), .waddr(cur_waddr),
    .wen(cur_wen), .nsel(cur_nsel)
  );

  for (genvar g = 0; g < NBR_COUNT; g++) begin : g_nbr
    assign nbr_arr[g] = nbr_i[g*DATA_W +: DATA_W];
  end
  assign nbr_pick = nbr_arr[cur_nsel];

  pe_local_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(cur_wen && !rst), .waddr(cur_waddr), .wdata(fu_y),
    .raddr_a(cur_raddr_a), .raddr_b(cur_raddr_b),
    .rdata_a(ram_a), .rdata_b(ram_b)
  );

  pe_operand_mux #(.DATA_W(DATA_W)) u_mux_a (
    .sel(cur_src_a), .ram_val(ram_a), .bus_val(bus_i), .nbr_val(nbr_pick),
    .operand(opnd_a)
  );

  pe_operand_mux #(.DATA_W(DATA_W)) u_mux_b (
    .sel(cur_src_b), .ram_val(ram_b), .bus_val(bus_i), .nbr_val(nbr_pick),
    .operand(opnd_b)
  );

  pe_fu #(.DATA_W(DATA_W)) u_fu (
    .op(cur_op), .a(opnd_a), .b(opnd_b), .y(fu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else begin
      res_q <= fu_y;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/pe_cell_chk.sv
module pe_cell_chk #(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        op,
  input logic [1:0]        src_a,
  input logic [1:0]        src_b,
  input logic [AW-1:0]     raddr_a,
  input logic [AW-1:0]     raddr_b
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> result_o == '0); // R1

  AST_BUS_PASS: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd8 && src_a == 2'd1) |=> result_o == $past(bus_i)); // R3

  AST_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (src_a == 2'd3 && src_b == 2'd3) |=> result_o == '0); // R3

  AST_XOR_SELF: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd4 && src_a == src_b && (src_a != 2'd0 || raddr_a == raddr_b))
      |=> result_o == '0); // R6

  AST_UNDEF_OP: assert property (@(posedge clk) disable iff (rst)
    (op > 4'd8) |=> result_o == '0); // R8
endmodule

bind pe_cell pe_cell_chk #(.DATA_W(DATA_W), .AW(AW)) u_pe_chk (
  .clk(clk), .rst(rst), .bus_i(bus_i), .result_o(result_o),
  .op(cur_op), .src_a(cur_src_a), .src_b(cur_src_b),
  .raddr_a(cur_raddr_a), .raddr_b(cur_raddr_b)
);

// File: tb/pe_cell_test.sv
`timescale 1ns/1ps
module pe_cell_test;
  localparam int CW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctx_load = 1'b0;
  logic [CW-1:0] ctx_word = '0;
  logic [15:0]   bus_i = '0;
  logic [63:0]   nbr_i = '0;
  logic [15:0]   result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0]   mram [8];
  logic [CW-1:0] mctx;
  bit            mheld;
  logic [15:0]   exp_res;
  string         exp_tag;

  always #2.5 clk = ~clk;

  pe_cell uut (
    .clk(clk), .rst(rst), .ctx_load(ctx_load), .ctx_word(ctx_word),
    .bus_i(bus_i), .nbr_i(nbr_i), .result_o(result_o)
  );

  function automatic logic [CW-1:0] mk(int op, int sa, int sb, int ra, int rb,
                                       int wa, int we, int ns);
    return {2'(ns), 1'(we), 3'(wa), 3'(rb), 3'(ra), 2'(sb), 2'(sa), 4'(op)};
  endfunction

  function automatic logic [15:0] ref_op(int op, logic [15:0] a, logic [15:0] b);
    logic [31:0] p;
    p = {16'b0, a} * {16'b0, b};
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return p[15:0];
      6: return a << b[3:0];
      7: return 16'($signed(a) >>> b[3:0]);
      8: return a;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] ref_src(int s, logic [15:0] r, logic [15:0] b,
                                          logic [15:0] n);
    case (s)
      0: return r;
      1: return b;
      2: return n;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: result_o=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock of stimulus; the model advances the active context by one cycle.
  task automatic step(input bit ld, input logic [CW-1:0] c, input logic [15:0] b,
                      input logic [63:0] n);
    int op, sa, sb, ra, rb, wa, ns;
    bit we;
    logic [15:0] a_v, b_v, nv, r;
    @(negedge clk);
    check(result_o, exp_res, exp_tag);
    ctx_load = ld; ctx_word = c; bus_i = b; nbr_i = n;
    op = int'(mctx[3:0]);   sa = int'(mctx[5:4]);   sb = int'(mctx[7:6]);
    ra = int'(mctx[10:8]);  rb = int'(mctx[13:11]); wa = int'(mctx[16:14]);
    we = mctx[17];          ns = int'(mctx[19:18]);
    nv  = n[ns*16 +: 16];
    a_v = ref_src(sa, mram[ra], b, nv);
    b_v = ref_src(sb, mram[rb], b, nv);
    r   = ref_op(op, a_v, b_v);
    if (we && ((sa == 0 && ra == wa) || (sb == 0 && rb == wa))) exp_tag = "R11";
    else if (mheld)                            exp_tag = "R2";
    else if (op > 8)                           exp_tag = "R8";
    else if (op == 6 || op == 7)               exp_tag = "R7";
    else if (op == 0 || op == 1 || op == 5)    exp_tag = "R5";
    else if (op != 8)                          exp_tag = "R6";
    else if (sa == 0)                          exp_tag = "R10";
    else if (sa == 1)                          exp_tag = "R3";
    else if (sa == 2)                          exp_tag = "R4";
    else                                       exp_tag = "R9";
    exp_res = r;
    if (we) mram[wa] = r;
    mheld = !ld;
    if (ld) mctx = c;
  endtask

  task automatic apply(input logic [CW-1:0] c, input logic [15:0] b, input logic [63:0] n);
    step(1'b1, c, 16'h0000, 64'h0);
    step(1'b0, c, b, n);
  endtask

  initial begin
    mctx = mk(8, 3, 3, 0, 0, 0, 0, 0);
    mheld = 0;
    exp_res = 16'h0000;
    exp_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(result_o, 16'h0000, "R1");
    // Fill every RAM word from the bus.
    for (int i = 0; i < 9; i++)
      step(i < 8, mk(8, 1, 3, 0, 0, i % 8, 1, 0), 16'(16'h0A00 + i * 16'h0111), 64'h0);
    // Each neighbour slot in turn.
    for (int k = 0; k < 4; k++)
      apply(mk(8, 2, 3, 0, 0, 0, 0, k), 16'h0000, 64'h4444_3333_2222_1111);
    // Arithmetic wrap and product truncation.
    apply(mk(5, 1, 2, 0, 0, 0, 0, 1), 16'h1234, 64'h0000_0000_5678_0000);
    apply(mk(0, 1, 2, 0, 0, 0, 0, 0), 16'hFFFF, 64'h0000_0000_0000_0002);
    apply(mk(1, 3, 1, 0, 0, 0, 0, 0), 16'h0001, 64'h0);
    // Shifts: negative arithmetic right, left with upper amount bits ignored.
    apply(mk(7, 1, 2, 0, 0, 0, 0, 3), 16'h8000, 64'h000F_0000_0000_0000);
    apply(mk(6, 1, 2, 0, 0, 0, 0, 2), 16'h0001, 64'h0000_0013_0000_0000);
    // Undefined opcodes.
    for (int o = 9; o < 16; o++)
      apply(mk(o, 1, 2, 0, 0, 0, 0, 0), 16'hBEEF, 64'hFFFF);
    // Read and write of one word in the same cycle, held over several cycles.
    step(1'b1, mk(0, 0, 1, 2, 0, 2, 1, 0), 16'h0000, 64'h0);
    for (int h = 0; h < 4; h++)
      step(1'b0, mk(0, 0, 1, 2, 0, 2, 1, 0), 16'(h + 3), 64'h0);
    // Write enable clear leaves word 5 intact; then read it back.
    apply(mk(8, 1, 3, 0, 0, 5, 0, 0), 16'hDEAD, 64'h0);
    apply(mk(8, 0, 3, 5, 0, 0, 0, 0), 16'h0000, 64'h0);
    // Random contexts, loaded on most cycles.
    for (int t = 0; t < 4000; t++)
      step(($urandom % 8) != 0, CW'($urandom), 16'($urandom), {$urandom, $urandom});
    step(1'b0, mk(8, 3, 3, 0, 0, 0, 0, 0), 16'h0000, 64'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule